// File: doc/BRIEF.md
# EPP Host Cycle Engine

This block is the host end of an enhanced parallel port bus of the 1.7 revision. A single register access from the host (an address write, a data write or a data read) becomes one handshaked transfer on an 8-bit bidirectional parallel bus. The host raises `req` with the access kind and holds it. The block holds the access in wait states and pulses `ready` for one clock when the transfer has finished. On the port side the block drives an active-low write line, an address strobe and a data strobe. It samples the peripheral's active-low wait line through a two-flop synchronizer, and it controls the output enable of the data bus.

The state machine has five states. ST_IDLE waits for a request. ST_SETUP presents the byte, or for a read leaves the bus released, with both strobes inactive. ST_STROBE holds one strobe low while the wait timer runs. ST_DONE raises the strobe and signals completion. ST_GAP is one quiet clock before the next request. The transitions are as follows. ST_IDLE goes to ST_SETUP on an accepted request, and to ST_DONE on a rejected one. ST_SETUP always goes to ST_STROBE. ST_STROBE goes to ST_DONE on a synchronized wait release or on timer expiry. ST_DONE always goes to ST_GAP, and ST_GAP always goes to ST_IDLE.

A transfer is allowed only under two conditions. The control register must hold zero in bits 0, 1 and 3, and its direction bit 5 must match the access: 0 for a write, 1 for a read. If the peripheral never releases the wait line, a programmable limit ends the transfer, sets a sticky timeout flag and, for a read, returns 0xFF.

Top module: `epp_host_engine`

## Requirements
- R1: A request is accepted only when ctrl bits 0, 1 and 3 are all 0, ctrl bit 5 equals 0 for a write (`wr`=1) or 1 for a read (`wr`=0), and a read is a data cycle (`is_addr`=0). Any other request finishes with `ready` and `err` high in the clock after it is seen, and neither strobe goes low. `err` is never high without `ready`.
- R2: `n_write` follows ctrl bit 5 and `pd_oe` follows its inverse, each one clock after the control value changes. Both reset to `n_write`=1 and `pd_oe`=0.
- R3: In a write, `pd_out` carries `wdata` for the full clock before the strobe falls and stays unchanged while the strobe is low, with `pd_oe` high.
- R4: An address cycle (`is_addr`=1) pulses only `n_astb` and a data cycle pulses only `n_dstb`. The two strobes are never low together.
- R5: The strobe stays low for at least one clock. If `n_wait` is already high when the strobe falls, the strobe stays low for exactly one clock. If `n_wait` rises at the falling clock edge that ends the strobe's D-th low clock, the strobe stays low for D+2 clocks.
- R6: The strobe stays low for at most `tmo_limit`+1 clocks. If the wait release arrives in that last clock, it takes priority and there is no timeout. A timeout sets `tmo_flag`, which stays high until reset.
- R7: In a read, `rdata` takes the `pd_in` value present at the clock edge that ends the strobe. After a timeout it takes 0xFF instead.
- R8: `ready` is high for exactly one clock. That clock is the first one in which the strobe is high again.
- R9: When `req` stays high, the next strobe falls four clocks after the `ready` clock, because one idle clock follows every completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Host access request, held until `ready` |
| is_addr | input | 1 | 1 = address cycle, 0 = data cycle |
| wr | input | 1 | 1 = write, 0 = read |
| wdata | input | DW | Byte to write |
| ctrl | input | 8 | Control register contents |
| tmo_limit | input | TW | Wait timeout limit in clocks, minus one |
| rdata | output | DW | Byte returned by a read |
| ready | output | 1 | One-clock completion pulse |
| err | output | 1 | Request rejected, valid with `ready` |
| tmo_flag | output | 1 | Sticky timeout status |
| n_write | output | 1 | Active-low write line |
| n_astb | output | 1 | Active-low address strobe |
| n_dstb | output | 1 | Active-low data strobe |
| pd_out | output | DW | Bus byte driven by the host |
| pd_oe | output | 1 | Bus output enable |
| pd_in | input | DW | Bus byte driven by the peripheral |
| n_wait | input | 1 | Active-low peripheral wait line |

## Verification
The bench builds the block with the default widths of 8 data bits and 8 timer bits, and drives `tmo_limit` from 0 to 4. With limits that small, every ordering between the wait release and timer expiry falls within a short run. This includes the release in the very clock the timer expires, a release held high from the start, and a limit of zero. A second sweep covers all 16 combinations of the four checked control bits against every access kind, so every rejection reason and every accepted direction is exercised.

// File: rtl/epp_host_pkg.sv
package epp_host_pkg;

    // Control-register bit positions checked before a transfer
    localparam int CB_ZERO_A = 0;
    localparam int CB_ZERO_B = 1;
    localparam int CB_ZERO_C = 3;
    localparam int CB_DIR    = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_DONE,
        ST_GAP
    } epp_state_e;

endpackage

// File: rtl/epp_wait_sync.sv
module epp_wait_sync #(
    parameter int  STAGES  = 2,
    parameter bit  RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/epp_wait_timer.sv
module epp_wait_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expired
);

    logic [TW-1:0] cnt_q;

    assign expired = (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/epp_req_check.sv
module epp_req_check
    import epp_host_pkg::*;
(
    input  logic [7:0] ctrl,
    input  logic       wr,
    input  logic       is_addr,
    output logic       ok
);

    localparam logic [7:0] ZERO_MASK = 8'((1 << CB_ZERO_A) | (1 << CB_ZERO_B) | (1 << CB_ZERO_C));
    localparam logic [7:0] DIR_MASK  = 8'(1 << CB_DIR);

    logic zero_ok;
    logic dir_ok;
    logic kind_ok;

    always_comb begin
        zero_ok = ((ctrl & ZERO_MASK) == 8'h00);
        dir_ok  = (((ctrl & DIR_MASK) != 8'h00) == !wr);
        kind_ok = wr || !is_addr;
        ok      = zero_ok && dir_ok && kind_ok;
    end

endmodule

// File: rtl/epp_host_engine.sv
module epp_host_engine
    import epp_host_pkg::*;
#(
    parameter int DW = 8,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          is_addr,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic [7:0]    ctrl,
    input  logic [TW-1:0] tmo_limit,
    output logic [DW-1:0] rdata,
    output logic          ready,
    output logic          err,
    output logic          tmo_flag,
    output logic          n_write,
    output logic          n_astb,
    output logic          n_dstb,
    output logic [DW-1:0] pd_out,
    output logic          pd_oe,
    input  logic [DW-1:0] pd_in,
    input  logic          n_wait
);

    epp_state_e state_q, state_d;

    logic          req_ok;
    logic          wait_rel;
    logic          tmo_exp;
    logic          finish;
    logic          kind_addr_q;
    logic          kind_wr_q;
    logic          err_q;
    logic          tmo_q;
    logic          nwrite_q;
    logic          oe_q;
    logic [DW-1:0] pd_q;
    logic [DW-1:0] rd_q;

    epp_req_check u_check (
        .ctrl    (ctrl),
        .wr      (wr),
        .is_addr (is_addr),
        .ok      (req_ok)
    );

    epp_wait_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (n_wait),
        .q     (wait_rel)
    );

    epp_wait_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (state_q == ST_SETUP),
        .run     (state_q == ST_STROBE),
        .limit   (tmo_limit),
        .expired (tmo_exp)
    );

    assign finish = wait_rel || tmo_exp;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req) state_d = req_ok ? ST_SETUP : ST_DONE;
            ST_SETUP:  state_d = ST_STROBE;
            ST_STROBE: if (finish) state_d = ST_DONE;
            ST_DONE:   state_d = ST_GAP;
            ST_GAP:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Access capture, bus byte, read result and status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_addr_q <= 1'b0;
            kind_wr_q   <= 1'b0;
            err_q       <= 1'b0;
            tmo_q       <= 1'b0;
            pd_q        <= '0;
            rd_q        <= '0;
            nwrite_q    <= 1'b1;
            oe_q        <= 1'b0;
        end else begin
            nwrite_q <= ctrl[CB_DIR];
            oe_q     <= !ctrl[CB_DIR];
            if (state_q == ST_IDLE && req) begin
                kind_addr_q <= is_addr;
                kind_wr_q   <= wr;
                err_q       <= !req_ok;
                if (req_ok && wr) begin
                    pd_q <= wdata;
                end
            end
            if (state_q == ST_STROBE && finish) begin
                if (!kind_wr_q) begin
                    rd_q <= wait_rel ? pd_in : '1;
                end
                if (!wait_rel) begin
                    tmo_q <= 1'b1;
                end
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        n_astb   = !(state_q == ST_STROBE && kind_addr_q);
        n_dstb   = !(state_q == ST_STROBE && !kind_addr_q);
        ready    = (state_q == ST_DONE);
        err      = (state_q == ST_DONE) && err_q;
        tmo_flag = tmo_q;
        n_write  = nwrite_q;
        pd_oe    = oe_q;
        pd_out   = pd_q;
        rdata    = rd_q;
    end

endmodule

// File: rtl/epp_host_engine_chk.sv
module epp_host_engine_chk #(
    parameter int DW = 8,
    parameter int TW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [TW-1:0] tmo_limit,
    input logic          ready,
    input logic          err,
    input logic          tmo_flag,
    input logic          n_write,
    input logic          n_astb,
    input logic          n_dstb,
    input logic [DW-1:0] pd_out,
    input logic          pd_oe
);

    logic        low_now;
    logic [TW:0] low_cnt_q;

    assign low_now = !n_astb || !n_dstb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
        end else if (low_now) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end else begin
            low_cnt_q <= '0;
        end
    end

    // R4
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!n_astb && !n_dstb));

    // R8
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    // R8
    rise_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(n_astb) || $rose(n_dstb)) |-> ready);

    // R1
    err_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ready);

    // R6
    tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_flag |=> tmo_flag);

    // R6
    strobe_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_now |-> (low_cnt_q <= {1'b0, tmo_limit}));

    // R3
    write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_now && !n_write) |-> pd_oe);

    // R3
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_now && $past(low_now) && !n_write) |-> $stable(pd_out));

endmodule

bind epp_host_engine epp_host_engine_chk #(.DW(DW), .TW(TW)) u_chk (.*);

// File: tb/epp_host_engine_tb.sv
module epp_host_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          is_addr = 1'b0;
    logic          wr = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [7:0]    ctrl = 8'h00;
    logic [TW-1:0] tmo_limit = '0;
    logic [DW-1:0] rdata;
    logic          ready, err, tmo_flag, n_write, n_astb, n_dstb, pd_oe;
    logic [DW-1:0] pd_out;
    logic [DW-1:0] pd_in = '0;
    logic          n_wait = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int d_cfg = 0;
    int per_cnt = 0;
    logic [DW-1:0] per_data = '0;
    bit exp_tmo = 1'b0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    epp_host_engine #(.DW(DW), .TW(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .is_addr(is_addr), .wr(wr),
        .wdata(wdata), .ctrl(ctrl), .tmo_limit(tmo_limit), .rdata(rdata),
        .ready(ready), .err(err), .tmo_flag(tmo_flag), .n_write(n_write),
        .n_astb(n_astb), .n_dstb(n_dstb), .pd_out(pd_out), .pd_oe(pd_oe),
        .pd_in(pd_in), .n_wait(n_wait)
    );

    // Peripheral model: releases wait after d_cfg strobe-low samples
    always @(negedge clk) begin
        if (!n_astb || !n_dstb) begin
            per_cnt = per_cnt + 1;
            if (d_cfg != 0 && per_cnt == d_cfg) begin
                n_wait = 1'b1;
                pd_in  = per_data;
            end
        end else begin
            per_cnt = 0;
            n_wait  = (d_cfg == 0);
            pd_in   = (d_cfg == 0) ? per_data : '0;
        end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // op: 0 addr write, 1 data write, 2 data read, 3 addr read
    task automatic access(input int op, input logic [7:0] c, input int d, input int lim,
                          input logic [DW-1:0] dat);
        bit is_wr = (op < 2);
        bit is_ad = (op == 0 || op == 3);
        bit valid = (c[0] == 0) && (c[1] == 0) && (c[3] == 0) && (c[5] == !is_wr) && (is_wr || !is_ad);
        bit tmo = valid && d != 0 && d >= lim;
        int exp_w = !valid ? 0 : (d == 0 ? 1 : (tmo ? lim + 1 : d + 2));
        int w_a = 0, w_d = 0, lat = 0;
        bit seen = 0, both = 0, pre_ok = 1, wr_ok = 1;
        logic [DW-1:0] prev_pd;
        @(negedge clk);
        ctrl = c; d_cfg = d; per_data = dat; tmo_limit = TW'(lim);
        repeat (3) @(negedge clk);
        chk(n_write == c[5], "R2 n_write", int'(n_write), int'(c[5]));
        chk(pd_oe == !c[5], "R2 pd_oe", int'(pd_oe), int'(!c[5]));
        req = 1'b1; wr = is_wr; is_addr = is_ad; wdata = dat;
        prev_pd = pd_out;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            lat++;
            if (!n_astb && !n_dstb) both = 1;
            if (!n_astb) w_a++;
            if (!n_dstb) w_d++;
            if ((!n_astb || !n_dstb) && is_wr) begin
                if (!seen && prev_pd !== dat) pre_ok = 0;
                if (pd_out !== dat || !pd_oe) wr_ok = 0;
                seen = 1;
            end
            prev_pd = pd_out;
            if (ready) break;
        end
        chk(ready == 1'b1, "R8 ready seen", int'(ready), 1);
        chk(n_astb && n_dstb, "R8 strobe high at ready", int'(n_astb & n_dstb), 1);
        chk(err == !valid, "R1 err", int'(err), int'(!valid));
        if (!valid) chk(lat == 1, "R1 reject latency", lat, 1);
        chk(!both, "R4 both strobes", int'(both), 0);
        chk((is_ad ? w_d : w_a) == 0, "R4 wrong strobe", is_ad ? w_d : w_a, 0);
        if (valid && d >= 1 && !tmo)
            chk((is_ad ? w_a : w_d) == exp_w, "R5 width", is_ad ? w_a : w_d, exp_w);
        else if (valid && !tmo)
            chk((is_ad ? w_a : w_d) == exp_w, "R5 width no wait", is_ad ? w_a : w_d, exp_w);
        else
            chk((is_ad ? w_a : w_d) == exp_w, "R6 width", is_ad ? w_a : w_d, exp_w);
        if (valid && is_wr) begin
            chk(pre_ok, "R3 setup byte", int'(prev_pd), int'(dat));
            chk(wr_ok, "R3 byte held", int'(pd_out), int'(dat));
        end
        if (valid && !is_wr)
            chk(rdata == (tmo ? 8'hFF : dat), "R7 rdata", int'(rdata), int'(tmo ? 8'hFF : dat));
        exp_tmo = exp_tmo | tmo;
        chk(tmo_flag == exp_tmo, "R6 tmo_flag", int'(tmo_flag), int'(exp_tmo));
        req = 1'b0;
        @(negedge clk);
        chk(!ready, "R8 ready one clock", int'(ready), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(n_write && !pd_oe, "R2 reset bus", int'({n_write, pd_oe}), 2);
        chk(n_astb && n_dstb && !ready && !tmo_flag, "R8 reset outputs",
            int'({n_astb, n_dstb, ready, tmo_flag}), 12);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // Rejection sweep over bits 0,1,3,5 against every access kind
        for (int c = 0; c < 16; c++) begin
            for (int op = 0; op < 4; op++) begin
                logic [7:0] cv = {2'b00, c[3], 1'b0, c[2], 1'b0, c[1], c[0]};
                access(op, cv, 0, 3, 8'(8'h5A + c * 7 + op));
            end
        end
        // Wait / timeout sweep
        for (int lim = 0; lim < 5; lim++) begin
            for (int d = 0; d < 7; d++) begin
                for (int op = 0; op < 3; op++) begin
                    access(op, (op == 2) ? 8'h20 : 8'h00, d, lim, 8'(8'h3C ^ (d * 17 + lim * 5 + op)));
                end
            end
        end
        // R9: request held across completion
        @(negedge clk);
        ctrl = 8'h00; d_cfg = 0; tmo_limit = 8'd3;
        repeat (3) @(negedge clk);
        req = 1'b1; wr = 1'b1; is_addr = 1'b0; wdata = 8'hA5;
        for (int i = 0; i < 32 && !ready; i++) @(negedge clk);
        begin
            int gap = 0;
            for (int i = 0; i < 16; i++) begin
                @(negedge clk);
                gap++;
                if (!n_dstb) break;
            end
            chk(gap == 4, "R9 idle gap", gap, 4);
        end
        req = 1'b0;
        repeat (8) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

endmodule